// File: doc/BRIEF.md
# Data-Driven Datapath Cell

This block is one processing cell for a mesh of identical cells that together form a reconfigurable datapath. Each cell holds two operand registers and two result registers. Operand A arrives from the west neighbour and operand B from the north neighbour. Results leave toward the east neighbour, the south neighbour, or both. Every link uses a valid/ready handshake. A transfer happens on a rising clock edge where both valid and ready are high.

No schedule drives the cell. It fires its configured operator as soon as the operands it needs are held and every result register it routes to is empty. A side bus driven by an outside controller can also load either operand register directly, and it can collect a result directly. Both bus paths use the same handshake and bypass the neighbour links. The cell takes a configuration word through its own handshake. The word is accepted only once the cell holds no data, so a reconfiguration needs no special timing against the data flow.

Top module: `dpu_cell`

## Requirements
- R1: After reset the cell holds no data: east_valid, south_valid and bout_valid are low and cfg_ready is high. The configuration defaults to PASS routed east, with both operands taken from the neighbour links and unit ID 0.
- R2: A configuration word is accepted (cfg_valid and cfg_ready both high) only when all four data registers are empty. The word layout is: bits [3:0] opcode, [5:4] route, [6] A from bus, [7] B from bus, and [8+ID_W-1:8] unit ID. While cfg_valid is high, no operand is accepted from any source.
- R3: An operand register accepts a value only while it is empty, and only from its configured source. A takes from west_* when its bus bit is 0, and B takes from north_* when its bus bit is 0. The ready of a source that is not selected stays low.
- R4: On the edge after the cell holds A (and B, for any opcode other than PASS) and every result register in its route is empty, it writes the result and empties its operand registers. A result register that is full blocks firing until it has been handed on.
- R5: The opcodes are 0 ADD, 1 SUB (A-B), 2 MUL (low W bits), 3 AND, 4 OR, 5 XOR, 6 SHL (A shifted left by B mod W), 7 SHR (logical, by B mod W), 8 LT (unsigned, result 1 or 0), 9 EQ (result 1 or 0) and 10 PASS (A). Codes 11 to 15 give 0.
- R6: The route codes are 0 bus (the result is offered on bout_*), 1 east, 2 south and 3 east and south. With route 3 each output is handed on independently.
- R7: A valid output keeps its valid high and its data unchanged until its consumer accepts it.
- R8: A bus load is accepted only when bin_addr equals the configured unit ID, the target register (bin_sel 0 for A, 1 for B) is configured for the bus, and that register is empty.
- R9: The bus is used by one transfer at a time: while a result is offered on bout_*, bin_ready stays low.
- R10: Under PASS, operand B is never needed, and both north_ready and the bus load into B stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Cell is empty and takes a configuration |
| cfg_word | input | 8+ID_W | Configuration word |
| west_valid | input | 1 | Operand A offered by west neighbour |
| west_ready | output | 1 | Operand A register takes the west value |
| west_data | input | W | West operand |
| north_valid | input | 1 | Operand B offered by north neighbour |
| north_ready | output | 1 | Operand B register takes the north value |
| north_data | input | W | North operand |
| east_valid | output | 1 | Result offered east |
| east_ready | input | 1 | East neighbour takes the result |
| east_data | output | W | East result |
| south_valid | output | 1 | Result offered south |
| south_ready | input | 1 | South neighbour takes the result |
| south_data | output | W | South result |
| bin_valid | input | 1 | Bus load offered |
| bin_ready | output | 1 | Bus load taken |
| bin_addr | input | ID_W | Target unit ID of the bus load |
| bin_sel | input | 1 | Target operand register: 0 A, 1 B |
| bin_data | input | W | Bus load value |
| bout_valid | output | 1 | Result offered on the bus |
| bout_ready | input | 1 | Controller takes the bus result |
| bout_data | output | W | Bus result |

## Verification
The handshake checks assume that neighbours and the controller follow the usual rules. The cell is also never offered a configuration change except through cfg_valid. The stimulus keeps to this: it changes valid and data only between edges, and it asserts cfg_valid only in phases that end once the word is accepted. Before each reconfiguration the bench completes any half-filled operand pair and drains the results. This keeps the wait for cfg_ready finite, because a lone operand A would otherwise hold the cell busy. Readies, valids, bus addresses and target selects are randomized within these rules.

// File: rtl/dpu_pkg.sv
package dpu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_SHL  = 4'd6,
    OP_SHR  = 4'd7,
    OP_LT   = 4'd8,
    OP_EQ   = 4'd9,
    OP_PASS = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    RT_BUS   = 2'd0,
    RT_EAST  = 2'd1,
    RT_SOUTH = 2'd2,
    RT_BOTH  = 2'd3
  } rt_e;

  localparam int CFG_FIXED_W = 8;
endpackage

// File: rtl/dpu_alu.sv
module dpu_alu #(
  parameter int W = 16
) (
  input  dpu_pkg::op_e  op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  y
);
  import dpu_pkg::*;
  localparam int SH_W = (W > 1) ? $clog2(W) : 1;

  logic [SH_W-1:0] sh;
  logic [2*W-1:0]  prod;

  assign sh   = b[SH_W-1:0];
  assign prod = a * b;

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = prod[W-1:0];
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SHL:  y = a << sh;
      OP_SHR:  y = a >> sh;
      OP_LT:   y = {{(W-1){1'b0}}, (a < b)};
      OP_EQ:   y = {{(W-1){1'b0}}, (a == b)};
      OP_PASS: y = a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/dpu_opnd.sv
module dpu_opnd #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         allow,
  input  logic         src_bus,
  input  logic         link_valid,
  input  logic [W-1:0] link_data,
  output logic         link_ready,
  input  logic         bus_hit,
  input  logic         bus_valid,
  input  logic [W-1:0] bus_data,
  output logic         bus_ready,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  logic ld_link, ld_bus;

  assign link_ready = allow && !src_bus && !full;
  assign bus_ready  = allow && src_bus && bus_hit && !full;
  assign ld_link    = link_ready && link_valid;
  assign ld_bus     = bus_ready && bus_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (ld_link || ld_bus) begin
      full <= 1'b1;
      data <= ld_link ? link_data : bus_data;
    end
  end
endmodule

// File: rtl/dpu_oreg.sv
module dpu_oreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ldata,
  input  logic         drain,
  output logic         full,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (load) begin
      full <= 1'b1;
      data <= ldata;
    end else if (drain) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/dpu_cell.sv
module dpu_cell #(
  parameter int W    = 16,
  parameter int ID_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_valid,
  output logic                 cfg_ready,
  input  logic [8+ID_W-1:0]    cfg_word,
  input  logic                 west_valid,
  output logic                 west_ready,
  input  logic [W-1:0]         west_data,
  input  logic                 north_valid,
  output logic                 north_ready,
  input  logic [W-1:0]         north_data,
  output logic                 east_valid,
  input  logic                 east_ready,
  output logic [W-1:0]         east_data,
  output logic                 south_valid,
  input  logic                 south_ready,
  output logic [W-1:0]         south_data,
  input  logic                 bin_valid,
  output logic                 bin_ready,
  input  logic [ID_W-1:0]      bin_addr,
  input  logic                 bin_sel,
  input  logic [W-1:0]         bin_data,
  output logic                 bout_valid,
  input  logic                 bout_ready,
  output logic [W-1:0]         bout_data
);
  import dpu_pkg::*;
  localparam int NOP = 2;  // operand slots: 0 = A (west), 1 = B (north)

  op_e             op_q;
  rt_e             rt_q;
  logic [NOP-1:0]  src_bus_q;
  logic [ID_W-1:0] id_q;

  logic [NOP-1:0]  op_full, op_allow, op_hit, op_lvalid, op_lready, op_bready;
  logic [W-1:0]    op_ldata [NOP];
  logic [W-1:0]    op_data  [NOP];
  logic            need_b, use_e, use_s, bus_busy, fire;
  logic            e_full, s_full, e_drain, s_drain;
  logic [W-1:0]    e_q, s_q, res;

  assign need_b   = (op_q != OP_PASS);
  assign use_e    = (rt_q != RT_SOUTH);
  assign use_s    = (rt_q == RT_SOUTH) || (rt_q == RT_BOTH);
  assign bus_busy = e_full && (rt_q == RT_BUS);

  assign op_allow[0] = !cfg_valid;
  assign op_allow[1] = !cfg_valid && need_b;
  assign op_lvalid[0] = west_valid;
  assign op_lvalid[1] = north_valid;
  assign op_ldata[0]  = west_data;
  assign op_ldata[1]  = north_data;

  for (genvar i = 0; i < NOP; i++) begin : g_opnd
    assign op_hit[i] = (bin_addr == id_q) && (bin_sel == 1'(i)) && !bus_busy;
    dpu_opnd #(.W(W)) u_opnd (
      .clk        (clk),
      .rst        (rst),
      .allow      (op_allow[i]),
      .src_bus    (src_bus_q[i]),
      .link_valid (op_lvalid[i]),
      .link_data  (op_ldata[i]),
      .link_ready (op_lready[i]),
      .bus_hit    (op_hit[i]),
      .bus_valid  (bin_valid),
      .bus_data   (bin_data),
      .bus_ready  (op_bready[i]),
      .take       (fire),
      .full       (op_full[i]),
      .data       (op_data[i])
    );
  end

  assign west_ready  = op_lready[0];
  assign north_ready = op_lready[1];
  assign bin_ready   = |op_bready;

  assign fire = op_full[0] && (op_full[1] || !need_b)
             && (!use_e || !e_full) && (!use_s || !s_full);

  dpu_alu #(.W(W)) u_alu (
    .op (op_q),
    .a  (op_data[0]),
    .b  (op_data[1]),
    .y  (res)
  );

  assign e_drain = e_full && ((rt_q == RT_BUS) ? bout_ready : east_ready);
  assign s_drain = s_full && south_ready;

  dpu_oreg #(.W(W)) u_oreg_e (
    .clk (clk), .rst (rst), .load (fire && use_e), .ldata (res),
    .drain (e_drain), .full (e_full), .data (e_q)
  );

  dpu_oreg #(.W(W)) u_oreg_s (
    .clk (clk), .rst (rst), .load (fire && use_s), .ldata (res),
    .drain (s_drain), .full (s_full), .data (s_q)
  );

  assign east_valid  = e_full && (rt_q != RT_BUS);
  assign east_data   = e_q;
  assign bout_valid  = e_full && (rt_q == RT_BUS);
  assign bout_data   = e_q;
  assign south_valid = s_full;
  assign south_data  = s_q;

  assign cfg_ready = !(|op_full) && !e_full && !s_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= OP_PASS;
      rt_q      <= RT_EAST;
      src_bus_q <= '0;
      id_q      <= '0;
    end else if (cfg_valid && cfg_ready) begin
      op_q      <= op_e'(cfg_word[3:0]);
      rt_q      <= rt_e'(cfg_word[5:4]);
      src_bus_q <= cfg_word[7:6];
      id_q      <= cfg_word[8+ID_W-1:8];
    end
  end
endmodule

// File: rtl/dpu_cell_chk.sv
module dpu_cell_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_ready,
  input logic         bin_ready,
  input logic         east_valid,
  input logic         east_ready,
  input logic [W-1:0] east_data,
  input logic         south_valid,
  input logic         south_ready,
  input logic [W-1:0] south_data,
  input logic         bout_valid,
  input logic         bout_ready,
  input logic [W-1:0] bout_data
);
  AST_BUS_ONE_USER: assert property (@(posedge clk) disable iff (rst)
    bout_valid |-> !bin_ready);  // R9
  AST_EAST_HOLD: assert property (@(posedge clk) disable iff (rst)
    east_valid && !east_ready |=> east_valid && $stable(east_data));  // R7
  AST_SOUTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    south_valid && !south_ready |=> south_valid && $stable(south_data));  // R7
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    bout_valid && !bout_ready |=> bout_valid && $stable(bout_data));  // R7
  AST_CFG_EMPTY: assert property (@(posedge clk) disable iff (rst)
    cfg_ready |-> !east_valid && !south_valid && !bout_valid);  // R2
  AST_ONE_EAST_PORT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({east_valid, bout_valid}));  // R6
endmodule

bind dpu_cell dpu_cell_chk #(.W(W)) u_chk (.*);

// File: tb/dpu_cell_tb.sv
`timescale 1ns/1ps
module dpu_cell_tb;
  localparam int W = 16;
  localparam int ID_W = 4;
  localparam int CW = 8 + ID_W;

  logic clk = 0, rst = 1;
  logic cfg_valid = 0; logic [CW-1:0] cfg_word = '0;
  logic west_valid = 0, north_valid = 0, bin_valid = 0, bin_sel = 0;
  logic [W-1:0] west_data = '0, north_data = '0, bin_data = '0;
  logic [ID_W-1:0] bin_addr = '0;
  logic east_ready = 0, south_ready = 0, bout_ready = 0;
  logic cfg_ready, west_ready, north_ready, east_valid, south_valid, bin_ready, bout_valid;
  logic [W-1:0] east_data, south_data, bout_data;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state (after each edge)
  bit m_af, m_bf, m_ef, m_sf, m_asb, m_bsb;
  logic [W-1:0] m_ad, m_bd, m_ed, m_sd;
  int m_op, m_rt;
  logic [ID_W-1:0] m_id;

  always #10 clk = ~clk;

  dpu_cell #(.W(W), .ID_W(ID_W)) u_dut (.*);

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_res(int op, logic [W-1:0] a, logic [W-1:0] b);
    logic [2*W-1:0] p;
    p = a * b;
    case (op)
      0: return a + b;
      1: return a - b;
      2: return p[W-1:0];
      3: return a & b;
      4: return a | b;
      5: return a ^ b;
      6: return a << (b % W);
      7: return a >> (b % W);
      8: return (a < b) ? 1 : 0;
      9: return (a == b) ? 1 : 0;
      10: return a;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_af = 0; m_bf = 0; m_ef = 0; m_sf = 0; m_asb = 0; m_bsb = 0;
    m_op = 10; m_rt = 1; m_id = 0;
  endtask

  // inputs already driven after a falling edge; compare then advance one cycle
  task automatic step();
    bit need_b, busy, e_rdy, a_l, b_l, a_b, b_b, c_rdy, fire, ue, us;
    logic [W-1:0] r;
    #1;
    need_b = (m_op != 10);
    busy   = m_ef && (m_rt == 0);
    a_l = !cfg_valid && !m_asb && !m_af;
    b_l = !cfg_valid && need_b && !m_bsb && !m_bf;
    a_b = !cfg_valid && m_asb && !m_af && bin_addr == m_id && !bin_sel && !busy;
    b_b = !cfg_valid && need_b && m_bsb && !m_bf && bin_addr == m_id && bin_sel && !busy;
    c_rdy = !m_af && !m_bf && !m_ef && !m_sf;
    chk("R3", "west_ready", W'(west_ready), W'(a_l));
    chk(need_b ? "R3" : "R10", "north_ready", W'(north_ready), W'(b_l));
    chk("R8", "bin_ready", W'(bin_ready), W'(a_b || b_b));
    chk("R2", "cfg_ready", W'(cfg_ready), W'(c_rdy));
    chk("R6", "east_valid", W'(east_valid), W'(m_ef && m_rt != 0));
    chk("R9", "bout_valid", W'(bout_valid), W'(m_ef && m_rt == 0));
    chk("R4", "south_valid", W'(south_valid), W'(m_sf));
    if (m_ef && m_rt != 0) chk("R5", "east_data", east_data, m_ed);
    if (m_ef && m_rt == 0) chk("R5", "bout_data", bout_data, m_ed);
    if (m_sf) chk("R7", "south_data", south_data, m_sd);
    // next state
    ue = (m_rt != 2); us = (m_rt >= 2);
    fire = m_af && (m_bf || !need_b) && (!ue || !m_ef) && (!us || !m_sf);
    r = ref_res(m_op, m_ad, m_bd);
    e_rdy = (m_rt == 0) ? bout_ready : east_ready;
    if (m_ef && e_rdy) m_ef = 0;
    if (m_sf && south_ready) m_sf = 0;
    if (fire) begin
      m_af = 0; m_bf = 0;
      if (ue) begin m_ef = 1; m_ed = r; end
      if (us) begin m_sf = 1; m_sd = r; end
    end
    if (a_l && west_valid) begin m_af = 1; m_ad = west_data; end
    if (a_b && bin_valid) begin m_af = 1; m_ad = bin_data; end
    if (b_l && north_valid) begin m_bf = 1; m_bd = north_data; end
    if (b_b && bin_valid) begin m_bf = 1; m_bd = bin_data; end
    if (cfg_valid && c_rdy) begin
      m_op = int'(cfg_word[3:0]); m_rt = int'(cfg_word[5:4]);
      m_asb = cfg_word[6]; m_bsb = cfg_word[7]; m_id = cfg_word[CW-1:8];
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle_inputs();
    west_valid = 0; north_valid = 0; bin_valid = 0; cfg_valid = 0;
    east_ready = 1; south_ready = 1; bout_ready = 1;
  endtask

  // complete any half pair and empty the results
  task automatic drain();
    for (int k = 0; k < 30; k++) begin
      idle_inputs();
      if (m_af && !m_bf && m_op != 10) begin
        if (m_bsb) begin bin_valid = 1; bin_addr = m_id; bin_sel = 1; bin_data = W'($urandom); end
        else begin north_valid = 1; north_data = W'($urandom); end
      end else if (m_bf && !m_af) begin
        if (m_asb) begin bin_valid = 1; bin_addr = m_id; bin_sel = 0; bin_data = W'($urandom); end
        else begin west_valid = 1; west_data = W'($urandom); end
      end
      step();
    end
    idle_inputs();
  endtask

  task automatic do_cfg(int op, int rt, bit asb, bit bsb, int id);
    drain();
    cfg_word = {ID_W'(id), bsb, asb, 2'(rt), 4'(op)};
    cfg_valid = 1;
    step();
    cfg_valid = 0;
    chk("R2", "config taken", W'(m_op == op && m_rt == rt), W'(1));
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      west_valid  = ($urandom % 2) == 0; west_data  = W'($urandom);
      north_valid = ($urandom % 2) == 0; north_data = W'($urandom);
      bin_valid   = ($urandom % 2) == 0; bin_data   = W'($urandom);
      bin_addr    = (($urandom % 3) == 0) ? (m_id ^ 1) : m_id;
      bin_sel     = $urandom % 2;
      east_ready  = ($urandom % 4) != 0;
      south_ready = ($urandom % 4) != 0;
      bout_ready  = ($urandom % 3) != 0;
      step();
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1", "east_valid at reset", W'(east_valid), 0);
    chk("R1", "south_valid at reset", W'(south_valid), 0);
    chk("R1", "bout_valid at reset", W'(bout_valid), 0);
    chk("R1", "cfg_ready at reset", W'(cfg_ready), 1);
    // R1 default PASS east: one value straight through
    west_valid = 1; west_data = 16'hBEEF; east_ready = 0; step();
    west_valid = 0; step(); step();
    chk("R1", "default pass data", east_data, 16'hBEEF);
    // R10 under PASS north is never taken
    north_valid = 1; run(20);
    // R5 every opcode, link sources, alternating routes
    for (int op = 0; op < 12; op++) begin
      do_cfg(op, 1 + (op % 3), 0, 0, op % 16);
      run(40);
    end
    // R5 hand-picked corner values
    do_cfg(8, 1, 0, 0, 3);
    west_valid = 1; west_data = 16'hFFFF; north_valid = 1; north_data = 16'h0001; step();
    idle_inputs(); step(); step();
    chk("R5", "LT unsigned max<1", east_data, 0);
    // R6 route to bus and both
    for (int rt = 0; rt < 4; rt++) begin
      do_cfg(0, rt, 0, 0, 5);
      run(40);
    end
    // R8 bus sources with matching and mismatching IDs
    do_cfg(1, 3, 1, 0, 7);  run(60);
    do_cfg(5, 1, 0, 1, 9);  run(60);
    do_cfg(2, 2, 1, 1, 12); run(60);
    // R9 bus load and bus store sharing the bus
    do_cfg(4, 0, 1, 1, 2);  run(80);
    do_cfg(10, 0, 1, 0, 6); run(60);
    // R2 cfg offered while busy keeps operands out until empty
    do_cfg(0, 1, 0, 0, 1);
    west_valid = 1; west_data = 16'h0010; east_ready = 0; step();
    north_valid = 1; north_data = 16'h0001; west_valid = 0; step();
    north_valid = 0; step();
    cfg_word = {ID_W'(4), 1'b0, 1'b0, 2'(1), 4'(1)}; cfg_valid = 1;
    west_valid = 1; north_valid = 1; step(); step();
    chk("R7", "held east data", east_data, 16'h0011);
    east_ready = 1; west_valid = 0; north_valid = 0; step(); step();
    cfg_valid = 0; step();
    chk("R2", "late config applied", W'(m_op), 1);
    drain();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule